// File: doc/BRIEF.md
# Control-Bit Preconditioned ALU

A combinational arithmetic logic unit that has no opcode. Six independent control bits steer a fixed cascade. Each operand may be cleared and then inverted. One function stage then forms either the sum or the bitwise AND of the two conditioned operands. The outcome may be inverted once more before it leaves the block. Alongside the data result, the block reports whether the result is zero and whether its sign bit is set.

Useful operations come out of combinations of these bits rather than from dedicated hardware. Examples are subtraction, negation, increment and small constants. A sequencer or instruction datapath drives the control bits directly and takes the result in the same cycle.

Top module: `ctrl_alu`

## Requirements
- R1: With `clr_x_i`=1 the x path is forced to all zeros before the invert stage; with `clr_x_i`=0, `x_i` passes unchanged.
- R2: `inv_x_i` inverts the output of the clear stage, not the raw input: {inv_x_i,clr_x_i} = 00 gives x, 01 gives 0, 10 gives ~x, 11 gives 16'hFFFF.
- R3: The y path behaves identically under `clr_y_i` followed by `inv_y_i`.
- R4: With `add_sel_i`=1 the function stage outputs the sum of the conditioned operands modulo 2^16; the carry out is dropped.
- R5: With `add_sel_i`=0 the function stage outputs the bitwise AND of the conditioned operands.
- R6: With `inv_out_i`=1 the function-stage output is bitwise inverted onto `result_o`; with 0 it passes unchanged.
- R7: `neg_o` equals bit 15 of `result_o`.
- R8: `zero_o` is 1 exactly when all 16 bits of `result_o` are 0.
- R9: Control words {clr_x,inv_x,clr_y,inv_y,add_sel,inv_out} produce these functions: 010011 gives x-y, 001111 gives -x, 011111 gives x+1, 111111 gives the constant 1.
- R10: The block is purely combinational. All outputs follow the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 16 | First operand, two's complement |
| y_i | input | 16 | Second operand, two's complement |
| clr_x_i | input | 1 | Clear x path |
| inv_x_i | input | 1 | Invert cleared x path |
| clr_y_i | input | 1 | Clear y path |
| inv_y_i | input | 1 | Invert cleared y path |
| add_sel_i | input | 1 | 1: sum, 0: bitwise AND |
| inv_out_i | input | 1 | Invert function output |
| result_o | output | 16 | Final result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result sign bit |

## Verification
Every output is due in the same cycle as its stimulus, with no register anywhere on the path. The bench applies operands and control bits just after a rising edge. It samples the result and both flags on the following falling edge, half a period later, so the combinational paths have settled and no edge ordering is involved. Each of the 64 control words is combined with a grid of corner operands and with pseudo-random operands. Four named control words are also compared against plain arithmetic rather than against the stage model.

// File: rtl/ctrl_alu_pkg.sv
package ctrl_alu_pkg;
  parameter int unsigned DATA_W = 16;

  typedef struct packed {
    logic clr;
    logic inv;
  } prep_ctrl_t;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned W = ctrl_alu_pkg::DATA_W
) (
  input  logic [W-1:0]              opd_i,
  input  ctrl_alu_pkg::prep_ctrl_t  ctrl_i,
  output logic [W-1:0]              opd_o
);
  logic [W-1:0] cleared;

  assign cleared = ctrl_i.clr ? '0 : opd_i;
  // invert acts on the cleared value, not the raw operand
  assign opd_o   = ctrl_i.inv ? ~cleared : cleared;

  always_comb begin
    if (ctrl_i.clr && !ctrl_i.inv) assert (opd_o == '0);            // R1
    if (ctrl_i.clr && ctrl_i.inv)  assert (&opd_o);                  // R2
    if (!ctrl_i.clr && ctrl_i.inv) assert ((opd_o ^ opd_i) == '1);   // R2
  end
endmodule

// File: rtl/alu_func_stage.sv
module alu_func_stage #(
  parameter int unsigned W = ctrl_alu_pkg::DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         add_sel_i,
  output logic [W-1:0] fn_o
);
  logic [W:0]   sum_full;
  logic [W-1:0] and_v;

  assign sum_full = {1'b0, a_i} + {1'b0, b_i};
  assign and_v    = a_i & b_i;
  // carry out dropped: modulo 2^W
  assign fn_o     = add_sel_i ? sum_full[W-1:0] : and_v;

  always_comb begin
    if (!add_sel_i) assert (((fn_o & ~a_i) | (fn_o & ~b_i)) == '0);  // R5
    if (add_sel_i)  assert (W'(fn_o - b_i) == a_i);                   // R4
  end
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int unsigned W = ctrl_alu_pkg::DATA_W
) (
  input  logic [W-1:0] fn_i,
  input  logic         inv_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o
);
  localparam int unsigned MSB = W - 1;

  assign res_o  = inv_i ? ~fn_i : fn_i;
  assign zero_o = ~|res_o;
  assign neg_o  = res_o[MSB];

  always_comb begin
    if (neg_o) assert (!zero_o);                                      // R8
    if (inv_i) assert ((res_o ^ fn_i) == '1);                         // R6
  end
endmodule

// File: rtl/ctrl_alu.sv
module ctrl_alu
  import ctrl_alu_pkg::*;
(
  input  logic [15:0] x_i,
  input  logic [15:0] y_i,
  input  logic        clr_x_i,
  input  logic        inv_x_i,
  input  logic        clr_y_i,
  input  logic        inv_y_i,
  input  logic        add_sel_i,
  input  logic        inv_out_i,
  output logic [15:0] result_o,
  output logic        zero_o,
  output logic        neg_o
);
  localparam int unsigned N_OPD = 2;

  logic [N_OPD-1:0][DATA_W-1:0] opd_raw, opd_prep;
  prep_ctrl_t [N_OPD-1:0]       prep_ctrl;
  logic [DATA_W-1:0]            fn_val;

  assign opd_raw[0]   = x_i;
  assign opd_raw[1]   = y_i;
  assign prep_ctrl[0] = '{clr: clr_x_i, inv: inv_x_i};
  assign prep_ctrl[1] = '{clr: clr_y_i, inv: inv_y_i};

  for (genvar g = 0; g < N_OPD; g++) begin : g_prep
    alu_operand_prep #(.W(DATA_W)) prep_i (
      .opd_i  (opd_raw[g]),
      .ctrl_i (prep_ctrl[g]),
      .opd_o  (opd_prep[g])
    );
  end

  alu_func_stage #(.W(DATA_W)) func_i (
    .a_i       (opd_prep[0]),
    .b_i       (opd_prep[1]),
    .add_sel_i (add_sel_i),
    .fn_o      (fn_val)
  );

  alu_out_stage #(.W(DATA_W)) out_i (
    .fn_i   (fn_val),
    .inv_i  (inv_out_i),
    .res_o  (result_o),
    .zero_o (zero_o),
    .neg_o  (neg_o)
  );

  always_comb begin
    if ({clr_x_i, inv_x_i, clr_y_i, inv_y_i, add_sel_i, inv_out_i} == 6'b111111)
      assert (result_o == 16'd1);                                     // R9
    if ({clr_x_i, inv_x_i, clr_y_i, inv_y_i, add_sel_i, inv_out_i} == 6'b011111)
      assert (result_o == 16'(x_i + 16'd1));                          // R9
  end
endmodule

// File: tb/ctrl_alu_tb_top.sv
`timescale 1ns/1ps
module ctrl_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] x, y;
  logic [5:0]  ctl;
  logic [15:0] res;
  logic        zr, ng;
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  ctrl_alu dut_i (
    .x_i (x), .y_i (y),
    .clr_x_i (ctl[5]), .inv_x_i (ctl[4]),
    .clr_y_i (ctl[3]), .inv_y_i (ctl[2]),
    .add_sel_i (ctl[1]), .inv_out_i (ctl[0]),
    .result_o (res), .zero_o (zr), .neg_o (ng)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [5:0] c);
    logic [15:0] pa, pb, f;
    pa = c[5] ? 16'h0000 : a;   // R1
    pa = c[4] ? ~pa : pa;       // R2
    pb = c[3] ? 16'h0000 : b;   // R3
    pb = c[2] ? ~pb : pb;
    f  = c[1] ? 16'((32'(pa) + 32'(pb)) % 32'h10000) : (pa & pb); // R4 R5
    return c[0] ? ~f : f;       // R6
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s ctl=%b x=%h y=%h actual=%h expected=%h", tag, ctl, x, y, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [5:0] c);
    logic [15:0] e;
    @(posedge clk);
    #1;
    x = a; y = b; ctl = c;
    @(negedge clk);  // R10: same-cycle, sampled half a period later
    e = model(a, b, c);
    check("R1/R2/R3/R4/R5/R6/R10 result", res, e);
    check("R8 zero", {15'd0, zr}, {15'd0, e == 16'h0000});
    check("R7 neg", {15'd0, ng}, {15'd0, e[15]});
  endtask

  task automatic named(input string tag, input logic [15:0] a, input logic [15:0] b,
                       input logic [5:0] c, input logic [15:0] e);
    @(posedge clk);
    #1;
    x = a; y = b; ctl = c;
    @(negedge clk);
    check(tag, res, e);
  endtask

  function automatic logic [15:0] corner(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      default: return 16'h8000;
    endcase
  endfunction

  initial begin
    x = 16'h0; y = 16'h0; ctl = 6'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset-idle result", res, 16'h0000);
    check("R8 reset-idle zero", {15'd0, zr}, 16'd1);

    // R9 derived functions against plain arithmetic
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < 5; j++) begin
        named("R9 x-y", corner(k), corner(j), 6'b010011, 16'(corner(k) - corner(j)));
      end
      named("R9 -x", corner(k), 16'h1234, 6'b001111, 16'(16'd0 - corner(k)));
      named("R9 x+1", corner(k), 16'h5A5A, 6'b011111, 16'(corner(k) + 16'd1));
      named("R9 const1", corner(k), corner(4 - k), 6'b111111, 16'h0001);
    end
    // R4 wrap: 0x7FFF + 1 and 0xFFFF + 0xFFFF
    named("R4 wrap", 16'h7FFF, 16'h0001, 6'b000010, 16'h8000);
    named("R4 wrap", 16'hFFFF, 16'hFFFF, 6'b000010, 16'hFFFE);

    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 5; k++)
        for (int j = 0; j < 5; j++)
          apply(corner(k), corner(j), 6'(c));
      for (int r = 0; r < 20; r++) begin
        logic [15:0] ra, rb;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        ra = lfsr[15:0] ^ lfsr[31:16];
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        rb = lfsr[23:8];
        apply(ra, rb, 6'(c));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule